// File: doc/BRIEF.md
# Interrupt Control and Status Register

This block is the 8-bit interrupt control register of a small microcontroller core. It collects three interrupt sources and keeps a sticky flag for each of them. The first source is a single-cycle timer rollover pulse. The second is an asynchronous external interrupt pin. The third is a change on any pin of a 6-pin general-purpose port, where each pin is qualified by a per-pin change mask held outside the block. Software reads and writes the register over a simple bus at either of two mirrored addresses. The block drives a single registered interrupt request towards the core.

Each flag latches whenever its condition occurs, whatever the enable bits hold. Software must clear a flag by writing a 0 to it, and should clear stale flags before it turns an enable on. The request is gated in two levels. The global enable masks everything. Below it, a peripheral group enable qualifies a pending request from the peripheral group, which arrives as an input, while the three local sources have enable bits of their own.

Top module: `irq_ctrl_reg`

## Requirements
- R1: After a synchronous active-high reset, all eight register bits read 0 and `irq_req` is 0.
- R2: A read at address 0x0B or 0x8B returns the register value combinationally. Any other address reads 0. The bit layout is: bit 7 global enable, bit 6 peripheral group enable, bit 5 timer enable, bit 4 external enable, bit 3 port-change enable, bit 2 timer flag, bit 1 external flag, bit 0 port-change flag.
- R3: A write at either of the two addresses loads all eight bits on the next clock edge. A write at any other address changes no bit.
- R4: A cycle with `tmr_ovf` high sets the timer flag on that clock edge, even when the enables are clear.
- R5: The external pin passes through a two-flop synchronizer, and only a rising edge sets the external flag. A rise that is set up before clock edge 1 is visible in the register after edge 3. A falling edge sets nothing.
- R6: A change of a port pin in either direction, with that pin's `chg_mask` bit set, sets the port-change flag with the same three-edge latency as R5. Changes on pins whose mask bit is clear are ignored.
- R7: Flags are sticky and clear only when software writes 0 to them. If a set event and a software write that clears the flag land in the same cycle, the flag ends up set.
- R8: `irq_req` is a register. One cycle after any register state, it equals global AND ((timer enable AND timer flag) OR (external enable AND external flag) OR (port enable AND port flag) OR (peripheral enable AND `periph_pend`)).
- R9: While the global enable is 0, `irq_req` is 0 on the following cycle, whatever the flags hold.
- R10: `periph_pend` raises a request only while both the peripheral group enable and the global enable are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Bus address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| tmr_ovf | input | 1 | Timer rollover pulse, synchronous |
| ext_pin | input | 1 | External interrupt pin, asynchronous |
| port_pins | input | 6 | General-purpose port pins, asynchronous |
| chg_mask | input | 6 | Per-pin change-detect enable |
| periph_pend | input | 1 | Pending request of the peripheral group |
| irq_req | output | 1 | Registered interrupt request |

## Verification
The collision that matters is a hardware flag set and a software write landing in the same cycle. The clearing write must not swallow the event. The bench provokes this by raising `tmr_ovf` in the very cycle in which it writes 0 to the register, and then expects the timer flag to read back as 1 with every enable cleared. A cycle-by-cycle reference model also runs alongside the design and judges every cycle, including the cycles in which a write and a synchronized pin or port edge coincide.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

  localparam int CTRL_W = 8;

  // bit positions, fixed because software decodes them
  localparam int BIT_GLB  = 7;
  localparam int BIT_PER  = 6;
  localparam int BIT_TEN  = 5;
  localparam int BIT_XEN  = 4;
  localparam int BIT_CEN  = 3;
  localparam int BIT_TFL  = 2;
  localparam int BIT_XFL  = 1;
  localparam int BIT_CFL  = 0;

  typedef struct packed {
    logic glb_en;
    logic per_en;
    logic tmr_en;
    logic ext_en;
    logic chg_en;
    logic tmr_fl;
    logic ext_fl;
    logic chg_fl;
  } ctrl_t;

  // request term of the local sources
  function automatic logic local_pending(input ctrl_t c);
    return (c.tmr_en & c.tmr_fl) | (c.ext_en & c.ext_fl) | (c.chg_en & c.chg_fl);
  endfunction

endpackage

// File: rtl/irq_sync_edge.sv
// Multi-stage synchronizer followed by an edge detector.
// RISE_ONLY=1 reports rising edges, RISE_ONLY=0 reports any toggle.
module irq_sync_edge #(
  parameter int WIDTH     = 1,
  parameter int STAGES    = 2,
  parameter bit RISE_ONLY = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] edge_o
);

  localparam int LAST = STAGES;

  // pipe[0..STAGES-1] synchronize, pipe[STAGES] holds the previous value
  logic [LAST:0][WIDTH-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe <= '0;
    end else begin
      pipe[0] <= din;
      for (int i = 1; i <= LAST; i++) begin
        pipe[i] <= pipe[i-1];
      end
    end
  end

  generate
    if (RISE_ONLY) begin : g_rise
      assign edge_o = pipe[LAST-1] & ~pipe[LAST];
    end else begin : g_toggle
      assign edge_o = pipe[LAST-1] ^ pipe[LAST];
    end
  endgenerate

endmodule

// File: rtl/irq_bus_dec.sv
// Address decode for the two mirrored locations and the read mux.
module irq_bus_dec
  import irq_ctrl_pkg::*;
#(
  parameter int                ADDR_W = 8,
  parameter logic [ADDR_W-1:0] ADDR_A = 8'h0B,
  parameter logic [ADDR_W-1:0] ADDR_B = 8'h8B
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  ctrl_t             ctrl_q,
  output logic              bus_hit,
  output logic [CTRL_W-1:0] bus_rdata
);

  always_comb begin
    bus_hit   = (bus_addr == ADDR_A) || (bus_addr == ADDR_B);
    bus_rdata = bus_hit ? ctrl_q : '0;
  end

endmodule

// File: rtl/irq_req_gate.sv
// Two-level request gating with a registered output.
module irq_req_gate
  import irq_ctrl_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  ctrl_t ctrl_q,
  input  logic  periph_pend,
  output logic  irq_req
);

  logic grp_req;
  logic req_d;

  always_comb begin
    grp_req = ctrl_q.per_en & periph_pend;
    req_d   = ctrl_q.glb_en & (local_pending(ctrl_q) | grp_req);
  end

  always_ff @(posedge clk) begin
    if (rst) irq_req <= 1'b0;
    else     irq_req <= req_d;
  end

endmodule

// File: rtl/irq_ctrl_reg.sv
module irq_ctrl_reg
  import irq_ctrl_pkg::*;
#(
  parameter int                ADDR_W      = 8,
  parameter int                PORT_W      = 6,
  parameter int                SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] ADDR_A      = 8'h0B,
  parameter logic [ADDR_W-1:0] ADDR_B      = 8'h8B
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [CTRL_W-1:0] bus_wdata,
  output logic [CTRL_W-1:0] bus_rdata,
  input  logic              tmr_ovf,
  input  logic              ext_pin,
  input  logic [PORT_W-1:0] port_pins,
  input  logic [PORT_W-1:0] chg_mask,
  input  logic              periph_pend,
  output logic              irq_req
);

  ctrl_t             ctrl_q;
  ctrl_t             ctrl_d;
  logic              bus_hit;
  logic [0:0]        ext_rise;
  logic [PORT_W-1:0] port_tog;
  logic              chg_evt;

  irq_bus_dec #(
    .ADDR_W (ADDR_W),
    .ADDR_A (ADDR_A),
    .ADDR_B (ADDR_B)
  ) u_dec (
    .bus_addr  (bus_addr),
    .ctrl_q    (ctrl_q),
    .bus_hit   (bus_hit),
    .bus_rdata (bus_rdata)
  );

  irq_sync_edge #(
    .WIDTH     (1),
    .STAGES    (SYNC_STAGES),
    .RISE_ONLY (1'b1)
  ) u_ext_sync (
    .clk    (clk),
    .rst    (rst),
    .din    (ext_pin),
    .edge_o (ext_rise)
  );

  irq_sync_edge #(
    .WIDTH     (PORT_W),
    .STAGES    (SYNC_STAGES),
    .RISE_ONLY (1'b0)
  ) u_port_sync (
    .clk    (clk),
    .rst    (rst),
    .din    (port_pins),
    .edge_o (port_tog)
  );

  irq_req_gate u_gate (
    .clk         (clk),
    .rst         (rst),
    .ctrl_q      (ctrl_q),
    .periph_pend (periph_pend),
    .irq_req     (irq_req)
  );

  // Software write first, hardware set events on top so that set wins.
  always_comb begin
    chg_evt = |(port_tog & chg_mask);
    ctrl_d  = ctrl_q;
    if (bus_wr && bus_hit) ctrl_d = ctrl_t'(bus_wdata);
    if (tmr_ovf)           ctrl_d.tmr_fl = 1'b1;
    if (ext_rise[0])       ctrl_d.ext_fl = 1'b1;
    if (chg_evt)           ctrl_d.chg_fl = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else     ctrl_q <= ctrl_d;
  end

endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk
  import irq_ctrl_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [7:0]        bus_addr,
  input logic              bus_wr,
  input logic [CTRL_W-1:0] bus_wdata,
  input logic [CTRL_W-1:0] bus_rdata,
  input logic              tmr_ovf,
  input logic              periph_pend,
  input logic              irq_req,
  input logic [CTRL_W-1:0] ctrl_q
);

  logic sel;
  assign sel = (bus_addr == 8'h0B) || (bus_addr == 8'h8B);

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (ctrl_q == '0) && !irq_req);

  assert_unmapped_zero_R2: assert property (@(posedge clk) disable iff (rst)
    !sel |-> bus_rdata == '0);

  assert_write_load_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && sel) |=> ctrl_q[7:3] == $past(bus_wdata[7:3]));

  assert_enables_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && sel) |=> $stable(ctrl_q[7:3]));

  assert_timer_set_R4: assert property (@(posedge clk) disable iff (rst)
    tmr_ovf |=> ctrl_q[BIT_TFL]);

  assert_flags_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && sel) |=> ((ctrl_q[2:0] & $past(ctrl_q[2:0])) == $past(ctrl_q[2:0])));

  assert_global_mask_R9: assert property (@(posedge clk) disable iff (rst)
    !ctrl_q[BIT_GLB] |=> !irq_req);

  assert_group_req_R10: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[BIT_GLB] && ctrl_q[BIT_PER] && periph_pend) |=> irq_req);

endmodule

bind irq_ctrl_reg irq_ctrl_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .bus_addr    (bus_addr),
  .bus_wr      (bus_wr),
  .bus_wdata   (bus_wdata),
  .bus_rdata   (bus_rdata),
  .tmr_ovf     (tmr_ovf),
  .periph_pend (periph_pend),
  .irq_req     (irq_req),
  .ctrl_q      (ctrl_q)
);

// File: tb/test_irq_ctrl_reg.sv
`timescale 1ns/1ps
module test_irq_ctrl_reg;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] bus_addr = 8'h00;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       tmr_ovf = 1'b0;
  logic       ext_pin = 1'b0;
  logic [5:0] port_pins = 6'h00;
  logic [5:0] chg_mask = 6'h00;
  logic       periph_pend = 1'b0;
  logic       irq_req;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  irq_ctrl_reg i_irq_ctrl_reg (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tmr_ovf(tmr_ovf),
    .ext_pin(ext_pin), .port_pins(port_pins), .chg_mask(chg_mask),
    .periph_pend(periph_pend), .irq_req(irq_req)
  );

  // ---------------- reference model ----------------
  bit [7:0] m_reg = 8'h00;
  bit       m_irq = 1'b0;
  bit       ext_hist[$]  = '{0, 0, 0, 0};
  bit [5:0] port_hist[$] = '{0, 0, 0, 0};

  function automatic bit mapped(input logic [7:0] a);
    return (a == 8'h0B) || (a == 8'h8B);
  endfunction

  always @(posedge clk) begin
    bit       rise;
    bit [5:0] delta;
    ext_hist.push_front(ext_pin);
    void'(ext_hist.pop_back());
    port_hist.push_front(port_pins);
    void'(port_hist.pop_back());
    if (rst) begin
      m_reg = 8'h00;
      m_irq = 1'b0;
    end else begin
      m_irq = m_reg[7] && ((m_reg[5] && m_reg[2]) || (m_reg[4] && m_reg[1]) ||
                           (m_reg[3] && m_reg[0]) || (m_reg[6] && periph_pend));
      if (bus_wr && mapped(bus_addr)) m_reg = bus_wdata;
      rise  = ext_hist[2] && !ext_hist[3];
      delta = (port_hist[2] ^ port_hist[3]) & chg_mask;
      if (tmr_ovf)     m_reg[2] = 1'b1;
      if (rise)        m_reg[1] = 1'b1;
      if (delta != 0)  m_reg[0] = 1'b1;
    end
    #5;
    checks++;
    if (bus_rdata !== (mapped(bus_addr) ? m_reg : 8'h00)) begin
      errors++;
      $display("FAIL R2 model rdata actual=%h expected=%h", bus_rdata,
               mapped(bus_addr) ? m_reg : 8'h00);
    end
    checks++;
    if (irq_req !== m_irq) begin
      errors++;
      $display("FAIL R8 model irq actual=%b expected=%b", irq_req, m_irq);
    end
  end

  // ---------------- helpers ----------------
  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic tmr_pulse();
    @(negedge clk); tmr_ovf = 1'b1;
    @(negedge clk); tmr_ovf = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #4000000;
    checks++; errors++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    finish_run();
  end

  // ---------------- directed sequence ----------------
  initial begin
    logic [7:0] v;
    idle(3);
    @(negedge clk); rst = 1'b0;
    rd(8'h0B, v); check8("R1 reset value", v, 8'h00);
    check8("R1 reset irq", {7'b0, irq_req}, 8'h00);

    wr(8'h0B, 8'hF8);
    rd(8'h8B, v); check8("R2 mirror read", v, 8'hF8);
    rd(8'h0C, v); check8("R2 unmapped read", v, 8'h00);
    wr(8'h0C, 8'h00);
    rd(8'h0B, v); check8("R3 unmapped write ignored", v, 8'hF8);
    wr(8'h8B, 8'h00);
    rd(8'h0B, v); check8("R3 mirror write", v, 8'h00);

    tmr_pulse();
    rd(8'h0B, v); check8("R4 timer flag with enables off", v, 8'h04);
    check8("R9 global off masks", {7'b0, irq_req}, 8'h00);

    @(negedge clk); ext_pin = 1'b1;
    idle(4);
    rd(8'h0B, v); check8("R5 external rise", v, 8'h06);
    wr(8'h0B, 8'h00);
    @(negedge clk); ext_pin = 1'b0;
    idle(4);
    rd(8'h0B, v); check8("R5 falling edge ignored", v, 8'h00);

    @(negedge clk); chg_mask = 6'b000001; port_pins = 6'b000010;
    idle(4);
    rd(8'h0B, v); check8("R6 unmasked pin ignored", v, 8'h00);
    @(negedge clk); port_pins = 6'b000011;
    idle(4);
    rd(8'h0B, v); check8("R6 masked pin change", v, 8'h01);
    wr(8'h0B, 8'h00);
    @(negedge clk); port_pins = 6'b000010;
    idle(4);
    rd(8'h0B, v); check8("R6 falling change", v, 8'h01);
    wr(8'h0B, 8'h00);

    tmr_pulse();
    idle(3);
    rd(8'h0B, v); check8("R7 flag sticky", v, 8'h04);
    wr(8'h0B, 8'h04);
    rd(8'h0B, v); check8("R7 write 1 keeps flag", v, 8'h04);
    wr(8'h0B, 8'h00);
    rd(8'h0B, v); check8("R7 write 0 clears", v, 8'h00);

    @(negedge clk);
    bus_addr = 8'h0B; bus_wdata = 8'h00; bus_wr = 1'b1; tmr_ovf = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; tmr_ovf = 1'b0;
    rd(8'h0B, v); check8("R7 set wins over clear", v, 8'h04);

    wr(8'h0B, 8'hA4);
    @(negedge clk);
    check8("R8 timer request", {7'b0, irq_req}, 8'h01);
    wr(8'h0B, 8'h24);
    idle(1);
    check8("R9 global cleared", {7'b0, irq_req}, 8'h00);

    wr(8'h0B, 8'h80);
    @(negedge clk); periph_pend = 1'b1;
    idle(2);
    check8("R10 group disabled", {7'b0, irq_req}, 8'h00);
    wr(8'h0B, 8'hC0);
    idle(1);
    check8("R10 group enabled", {7'b0, irq_req}, 8'h01);
    @(negedge clk); periph_pend = 1'b0;
    idle(2);
    check8("R10 pending dropped", {7'b0, irq_req}, 8'h00);

    @(negedge clk); rst = 1'b1;
    idle(2);
    @(negedge clk); rst = 1'b0;
    rd(8'h0B, v); check8("R1 second reset", v, 8'h00);

    idle(2);
    finish_run();
  end

endmodule